// File: doc/BRIEF.md
# Cluster Coherency Unit Register Block

This block is the software-visible register set of a cache-coherency unit in a small multiprocessor cluster. It decodes a 256-byte window on a plain 32-bit register bus. The bus carries an address, a read strobe, a write strobe, an access size in bytes and write data. Read data comes back one clock after the read strobe.

The live registers are few:
- a one-bit enable flag;
- a read-only identity word derived from the number of processors in the cluster;
- a 32-bit processor power word that can be written through any of its four byte addresses.

Every other address in the window reads as zero and ignores writes. This includes the invalidate command, the two filter-range addresses and the two access-permission addresses. The coherency machinery itself lives elsewhere and only consumes these values.

The bus is a control interface, so its pins are plain strobes with no valid/ready handshake. The block never stalls. A write takes effect at the clock edge that samples it. A read strobe is answered on the next cycle, and the returned value stays on the read-data pins until the next read strobe.

Top module: `cluster_csr`

## Requirements
- R1: After the first reset, the enable flag and the whole power word read as 0.
- R2: A write of a legal size to address 0x00 stores only bit 0 of the write data. A read of 0x00 returns that bit in bit 0, with bits 31:1 zero.
- R3: A read of 0x04 returns ((2^N − 1) << 4) | (N − 1), where N is the parameter NUM_CPU (1 to 4).
- R4: Writes to 0x04 change nothing.
- R5: A read of 0x08+k (k = 0..3) returns the power word shifted right by 8·k, with zeros filling from the top.
- R6: A write of size S bytes (S = 1, 2 or 4) at 0x08+k replaces byte lanes k to k+S−1 of the power word with write-data bytes 0 to S−1. Lanes above 3 are dropped, and all other lanes keep their value.
- R7: A write whose size field (3 bits, value = byte count) is not 1, 2 or 4 changes no register.
- R8: Every address other than 0x00, 0x04 and 0x08–0x0B reads as 0 and ignores writes. This includes 0x0C, 0x40, 0x44, 0x50 and 0x54.
- R9: Any reset after the first clears the enable flag and leaves the power word unchanged.
- R10: Read data appears in the cycle after the read strobe and holds its value while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte offset within the window |
| size | input | 3 | Access size in bytes |
| wdata | input | 32 | Write data, least significant byte first |
| rdata | output | 32 | Registered read data |

## Verification
The power word is driven with every pairing of the four byte offsets and the three legal sizes. Each write uses a data pattern with distinct bytes, placed on top of a known non-zero background. Reading all four offsets afterwards shows three things: whether the correct lanes moved, whether the lanes outside the write kept their value, and whether bytes that would shift past bit 31 are truncated.

The five illegal sizes are replayed against the enable flag and the power word, which separates a size-filtered write from one that is merely masked. A sweep over all 256 addresses with all-ones writes shows that no dead address aliases onto a live register. A second reset, applied after the power word holds a pattern, separates the first reset from later ones.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int LANES  = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h04;
  localparam logic [ADDR_W-3:0] PWR_WORD = 6'h02;  // addr[7:2] of 0x08..0x0B

  function automatic logic size_legal(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [2:0] s);
    case (s)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd4:    return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/csr_cfg_word.sv
module csr_cfg_word #(
  parameter int NUM_CPU = 1
) (
  output logic [31:0] cfg
);
  localparam logic [31:0] CPU_BITS = (32'd1 << NUM_CPU) - 32'd1;
  localparam logic [31:0] CPU_LAST = NUM_CPU - 1;

  assign cfg = (CPU_BITS << 4) | CPU_LAST;
endmodule

// File: rtl/csr_pwr_word.sv
module csr_pwr_word
  import csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [1:0]        lane_ofs,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word
);
  logic              primed = 1'b0;
  logic [DATA_W-1:0] mask_sh;
  logic [DATA_W-1:0] data_sh;

  assign mask_sh = size_mask(size) << {lane_ofs, 3'b000};
  assign data_sh = wdata << {lane_ofs, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b1;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst && !primed)
        lane_q <= 8'h00;
      else if (upd && mask_sh[8*j])
        lane_q <= data_sh[8*j +: 8];
    end
    assign word[8*j +: 8] = lane_q;
  end
endmodule

// File: rtl/csr_rd_mux.sv
module csr_rd_mux
  import csr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctrl,
  input  logic [DATA_W-1:0] cfg,
  input  logic [DATA_W-1:0] pwr,
  output logic [DATA_W-1:0] rd_val
);
  always_comb begin
    if (addr == OFF_CTRL)
      rd_val = {{(DATA_W-1){1'b0}}, ctrl};
    else if (addr == OFF_CFG)
      rd_val = cfg;
    else if (addr[ADDR_W-1:2] == PWR_WORD)
      rd_val = pwr >> {addr[1:0], 3'b000};
    else
      rd_val = '0;
  end
endmodule

// File: rtl/cluster_csr.sv
module cluster_csr
  import csr_pkg::*;
#(
  parameter int NUM_CPU = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [2:0]  size,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic              wr_ok;
  logic              ctrl_bit;
  logic [DATA_W-1:0] cfg_word;
  logic [DATA_W-1:0] pwr_word;
  logic [DATA_W-1:0] rd_val;

  assign wr_ok = wr_en && size_legal(size);

  csr_cfg_word #(.NUM_CPU(NUM_CPU)) u_cfg (.cfg(cfg_word));

  csr_pwr_word u_pwr (
    .clk      (clk),
    .rst      (rst),
    .upd      (wr_ok && (addr[ADDR_W-1:2] == PWR_WORD)),
    .lane_ofs (addr[1:0]),
    .size     (size),
    .wdata    (wdata),
    .word     (pwr_word)
  );

  csr_rd_mux u_mux (
    .addr   (addr),
    .ctrl   (ctrl_bit),
    .cfg    (cfg_word),
    .pwr    (pwr_word),
    .rd_val (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_bit <= 1'b0;
    else if (wr_ok && addr == OFF_CTRL)
      ctrl_bit <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_val;
  end
endmodule

// File: rtl/cluster_csr_chk.sv
module cluster_csr_chk #(
  parameter int NUM_CPU = 1
) (
  input logic        clk,
  input logic        rst,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic [2:0]  size,
  input logic [31:0] rdata,
  input logic [31:0] pwr_q,
  input logic        ctrl_q
);
  function automatic logic [31:0] expect_cfg();
    logic [31:0] v = 32'(NUM_CPU - 1);
    for (int i = 0; i < NUM_CPU; i++) v[4+i] = 1'b1;
    return v;
  endfunction

  function automatic logic dead_addr(input logic [7:0] a);
    return !(a == 8'h00 || a == 8'h04 || (a >= 8'h08 && a <= 8'h0B));
  endfunction

  // R10
  hold_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R2
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 8'h00) |=> (rdata[31:1] == 31'd0));

  // R3
  cfg_value_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 8'h04) |=> (rdata == expect_cfg()));

  // R7
  bad_size_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(size == 3'd1 || size == 3'd2 || size == 3'd4)) |=> $stable(pwr_q));

  // R7
  bad_size_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(size == 3'd1 || size == 3'd2 || size == 3'd4)) |=> $stable(ctrl_q));

  // R8
  dead_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && dead_addr(addr)) |=> (rdata == 32'd0));

  // R8
  dead_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dead_addr(addr)) |=> ($stable(pwr_q) && $stable(ctrl_q)));
endmodule

bind cluster_csr cluster_csr_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rd_en  (rd_en),
  .wr_en  (wr_en),
  .addr   (addr),
  .size   (size),
  .rdata  (rdata),
  .pwr_q  (pwr_word),
  .ctrl_q (ctrl_bit)
);

// File: tb/test_cluster_csr.sv
module test_cluster_csr;
  localparam int NCPU = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] model;
  logic [31:0] got;

  always #10 clk = ~clk;  // 50 MHz

  cluster_csr #(.NUM_CPU(NCPU)) i_cluster_csr (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .size(size), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic check_pwr(input string req, input logic [31:0] exp);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(8'h08 + 8'(k), v);
      check(req, v, exp >> (8 * k));
    end
  endtask

  function automatic logic [31:0] lane_merge(input logic [31:0] old, input int k,
                                             input int s, input logic [31:0] d);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++)
      if (b >= k && b < k + s) r[8*b +: 8] = d[8*(b-k) +: 8];
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(8'h00, got); check("R1", got, 32'd0);
    check_pwr("R1", 32'd0);

    // R3 / R4 configuration word
    rd(8'h04, got); check("R3", got, ((32'd1 << NCPU) - 1) * 16 + NCPU - 1);
    wr(8'h04, 3'd4, 32'hFFFF_FFFF);
    rd(8'h04, got); check("R4", got, ((32'd1 << NCPU) - 1) * 16 + NCPU - 1);

    // R2 control bit
    wr(8'h00, 3'd4, 32'hFFFF_FFFE); rd(8'h00, got); check("R2", got, 32'd0);
    wr(8'h00, 3'd1, 32'h0000_0003); rd(8'h00, got); check("R2", got, 32'd1);
    wr(8'h00, 3'd2, 32'h0000_0000); rd(8'h00, got); check("R2", got, 32'd0);

    // R5 / R6 every offset with every legal size
    model = 32'd0;
    for (int k = 0; k < 4; k++) begin
      for (int si = 0; si < 3; si++) begin
        int s;
        logic [31:0] d;
        s = (si == 2) ? 4 : si + 1;
        wr(8'h08, 3'd4, 32'h5A5A_5A5A);
        model = 32'h5A5A_5A5A;
        d = 32'h1020_3040 + 32'(k * 16 + si);
        wr(8'h08 + 8'(k), 3'(s), d);
        model = lane_merge(model, k, s, d);
        check_pwr("R6", model);
      end
    end
    wr(8'h09, 3'd4, 32'hAABB_CCDD);
    model = lane_merge(model, 1, 4, 32'hAABB_CCDD);
    check_pwr("R5", model);

    // R7 illegal sizes leave everything unchanged
    wr(8'h00, 3'd1, 32'd1);
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2 || s == 4) continue;
      wr(8'h08, 3'(s), ~model);
      wr(8'h0A, 3'(s), ~model);
      wr(8'h00, 3'(s), 32'd0);
      check_pwr("R7", model);
      rd(8'h00, got); check("R7", got, 32'd1);
    end

    // R8 dead addresses
    for (int a = 0; a < 256; a++) begin
      if (a == 0 || a == 4 || (a >= 8 && a <= 11)) continue;
      wr(8'(a), 3'd4, 32'hFFFF_FFFF);
      rd(8'(a), got); check("R8", got, 32'd0);
    end
    rd(8'h00, got); check("R8", got, 32'd1);
    check_pwr("R8", model);

    // R9 second reset keeps the power word
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(8'h00, got); check("R9", got, 32'd0);
    check_pwr("R9", model);

    // R10 latency and hold
    @(negedge clk); rd_en = 1'b1; addr = 8'h04;
    @(negedge clk); rd_en = 1'b0; addr = 8'h08;
    check("R10", rdata, ((32'd1 << NCPU) - 1) * 16 + NCPU - 1);
    repeat (3) @(negedge clk);
    check("R10", rdata, ((32'd1 << NCPU) - 1) * 16 + NCPU - 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule